// File: doc/BRIEF.md
# Exception Mode and Enable Stack Controller

This block holds the exception state of a small pipelined processor. A six-bit status field works as a three-level stack. Each level is a two-bit entry made of a privilege bit and a global interrupt-enable bit. The lowest level is the current mode, the middle level is the previous mode, and the top level is the oldest. Next to the stack sit an exception-PC register, which holds the resume address, and a cause register, which records why the last exception was taken. No memory stack is used: nesting depth is limited to the three levels held in the status field.

Each cycle the block decides whether an exception is taken. A synchronous request from the pipeline is always taken. An external interrupt is taken only when the current level has interrupts enabled. In the same cycle the block drives the handler entry address, chosen by exception class. On the next clock edge it does three things: it saves the resume address, records the cause, and pushes a privileged, interrupts-off entry onto the stack. A return-from-exception strobe pops the stack. Software reaches all three registers through a small read/write port. Reads are combinational and writes take effect on the following cycle.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the status field reads 6'b000010, so only the current level is privileged and every enable bit is 0. The exception-PC and cause registers read 0 and `exc_taken` is 0.
- R2: `exc_taken` is 1 in the same cycle whenever `sync_req` is 1. With `sync_req` at 0, `exc_taken` is 1 only when some `irq_lines` bit is 1 and the current enable bit (status bit 0) is 1.
- R3: While `exc_taken` is 1, `handler_pc` gives the handler address in the same cycle. Class 2 (reset) gives VEC_RESET, class 1 (translation miss) gives VEC_XLAT, and class 0, class 3 and every interrupt give VEC_GENERAL. While `exc_taken` is 0, `handler_pc` is 0.
- R4: One cycle after an exception is taken, the status field equals {previous, current, 2'b10}. Bits [1:0] are the current level, [3:2] the previous level and [5:4] the old level. In each level the upper bit is privilege (1 = privileged) and the lower bit is enable. The old level's prior value is discarded.
- R5: One cycle after an exception is taken, the exception-PC register holds the `pc_in` value from the cycle in which the exception was taken.
- R6: One cycle after an exception is taken, cause bits [4:0] hold the exception code and bits [13:8] hold `irq_lines` from the entry cycle. All other cause bits are 0. The code is `sync_code` for a synchronous request and 0 for an interrupt. When a synchronous request and an interrupt arrive together, the synchronous request sets the code.
- R7: One cycle after `rfe` is 1 with no exception taken, the status field equals {old, old, previous}, so the old level keeps its value.
- R8: When events coincide, an exception takes priority over `rfe`, and both take priority over a software write to the status or exception-PC register.
- R9: A software write (`sw_we` = 1) is visible on `sw_rdata` from the next cycle. Address 0 writes status bits [5:0] and address 2 writes the exception-PC register. Reads are combinational on `sw_addr`: address 0 gives status, 1 gives cause, 2 gives exception-PC, and 3 gives 0.
- R10: A software write to address 1 (cause) or address 3 leaves every register unchanged.
- R11: `priv_mode` equals status bit 1 and `irq_en` equals status bit 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_in | input | AW | Resume address of the instruction being interrupted |
| sync_req | input | 1 | Synchronous exception request from the pipeline |
| sync_class | input | 2 | Class of the synchronous request (0 general, 1 translation miss, 2 reset) |
| sync_code | input | 5 | Exception code of the synchronous request |
| irq_lines | input | NIRQ | External interrupt request lines |
| rfe | input | 1 | Return-from-exception strobe |
| sw_we | input | 1 | Software write enable |
| sw_addr | input | 2 | Software register select |
| sw_wdata | input | DW | Software write data |
| sw_rdata | output | DW | Software read data (combinational) |
| exc_taken | output | 1 | An exception is taken this cycle |
| handler_pc | output | AW | Handler entry address for the exception taken this cycle |
| priv_mode | output | 1 | Current privilege bit |
| irq_en | output | 1 | Current global interrupt-enable bit |

## Verification
`exc_taken` and `handler_pc` are combinational, so the bench samples them 5 ns after driving the inputs, in the same cycle. The stack, exception-PC and cause results are due one edge after the stimulus. The bench reads them back through `sw_rdata` at the falling edge after that edge, once the request inputs have been cleared. Software writes follow the same one-edge rule. Reads settle 1 ns after `sw_addr` changes, and the bench samples them at that point.

// File: rtl/exc_ctrl_pkg.sv
// Shared types and constants for the exception controller.
// Assumes a two-bit level made of {privilege, enable}.
package exc_ctrl_pkg;

    localparam int LVL_W    = 2;
    localparam int CODE_W   = 5;
    localparam int CLS_W    = 2;
    localparam int SEL_W    = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_GENERAL   = 2'd0,
        CLS_XLAT_MISS = 2'd1,
        CLS_RESET     = 2'd2,
        CLS_SPARE     = 2'd3
    } exc_class_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic priv;
        logic ie;
    } mode_lvl_t;

    localparam mode_lvl_t ENTRY_LVL = '{priv: 1'b1, ie: 1'b0};
    localparam logic [CODE_W-1:0] CODE_INTERRUPT = '0;

endpackage

// File: rtl/exc_entry_sel.sv
// Decides whether an exception is taken this cycle, which code it carries
// and which handler address it uses. Purely combinational.
// Assumes synchronous requests outrank interrupts.
module exc_entry_sel
    import exc_ctrl_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          NIRQ        = 6,
    parameter logic [AW-1:0] VEC_RESET   = 32'hBFC0_0000,
    parameter logic [AW-1:0] VEC_XLAT    = 32'h8000_0000,
    parameter logic [AW-1:0] VEC_GENERAL = 32'h8000_0080
) (
    input  logic              sync_req,
    input  logic [CLS_W-1:0]  sync_class,
    input  logic [CODE_W-1:0] sync_code,
    input  logic [NIRQ-1:0]   irq_lines,
    input  logic              ie_cur,
    output logic              take,
    output logic [CODE_W-1:0] code,
    output logic [AW-1:0]     vector
);

    logic irq_take;

    // Interrupt is accepted only with the current enable set.
    always_comb irq_take = (|irq_lines) && ie_cur;

    // Take decision and code choice, synchronous first.
    always_comb begin
        take = sync_req || irq_take;
        code = sync_req ? sync_code : CODE_INTERRUPT;
    end

    // Handler address by class; interrupts use the general entry.
    always_comb begin
        vector = '0;
        if (sync_req) begin
            case (exc_class_e'(sync_class))
                CLS_RESET:     vector = VEC_RESET;
                CLS_XLAT_MISS: vector = VEC_XLAT;
                default:       vector = VEC_GENERAL;
            endcase
        end else if (irq_take) begin
            vector = VEC_GENERAL;
        end
    end

endmodule

// File: rtl/exc_mode_stack.sv
// Status field as a stack of mode levels. Level 0 is current.
// Push on exception, pop on return; software write is lowest priority.
// Assumes push, pop and write requests are already qualified.
module exc_mode_stack
    import exc_ctrl_pkg::*;
#(
    parameter int LEVELS = 3,
    localparam int STK_W = LEVELS * LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             wr_en,
    input  logic [STK_W-1:0] wr_data,
    output logic [STK_W-1:0] status
);

    mode_lvl_t lvl_q [LEVELS];
    mode_lvl_t lvl_d [LEVELS];

    for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
        // Next value of one level under push, pop or write.
        always_comb begin
            lvl_d[i] = lvl_q[i];
            if (push) begin
                if (i == 0) lvl_d[i] = ENTRY_LVL;
                else        lvl_d[i] = lvl_q[(i == 0) ? 0 : i-1];
            end else if (pop) begin
                if (i < LEVELS-1) lvl_d[i] = lvl_q[(i < LEVELS-1) ? i+1 : i];
            end else if (wr_en) begin
                lvl_d[i] = mode_lvl_t'(wr_data[i*LVL_W +: LVL_W]);
            end
        end

        // Level storage; reset leaves only the current level privileged.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[i] <= (i == 0) ? ENTRY_LVL : mode_lvl_t'('0);
            else        lvl_q[i] <= lvl_d[i];
        end

        // Flatten the level into the status field.
        assign status[i*LVL_W +: LVL_W] = lvl_q[i];
    end

endmodule

// File: rtl/exc_capture_regs.sv
// Exception-PC and cause registers. Both load on a taken exception;
// software may also load the exception-PC. Cause is hardware-only.
// Assumes take outranks the software write.
module exc_capture_regs
    import exc_ctrl_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int NIRQ    = 6,
    parameter int IRQ_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [AW-1:0]     pc_in,
    input  logic [CODE_W-1:0] code,
    input  logic [NIRQ-1:0]   irq_lines,
    input  logic              epc_we,
    input  logic [AW-1:0]     epc_wdata,
    output logic [AW-1:0]     epc,
    output logic [DW-1:0]     cause
);

    logic [DW-1:0] cause_d;

    // Pack the code and the pending lines into the cause layout.
    always_comb begin
        cause_d = '0;
        cause_d[CODE_W-1:0]        = code;
        cause_d[IRQ_LSB +: NIRQ]   = irq_lines;
    end

    // Resume address: exception first, then software.
    always_ff @(posedge clk) begin
        if (!rst_n)      epc <= '0;
        else if (take)   epc <= pc_in;
        else if (epc_we) epc <= epc_wdata;
    end

    // Cause record, loaded only on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)    cause <= '0;
        else if (take) cause <= cause_d;
    end

endmodule

// File: rtl/exc_ctrl_unit.sv
// Top of the exception controller: entry selection, mode stack,
// capture registers and the software read/write port.
// Assumes one request set per cycle; rfe is a one-cycle strobe.
module exc_ctrl_unit
    import exc_ctrl_pkg::*;
#(
    parameter int            AW          = 32,
    parameter int            DW          = 32,
    parameter int            NIRQ        = 6,
    parameter int            LEVELS      = 3,
    parameter int            IRQ_LSB     = 8,
    parameter logic [AW-1:0] VEC_RESET   = 32'hBFC0_0000,
    parameter logic [AW-1:0] VEC_XLAT    = 32'h8000_0000,
    parameter logic [AW-1:0] VEC_GENERAL = 32'h8000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     pc_in,
    input  logic              sync_req,
    input  logic [CLS_W-1:0]  sync_class,
    input  logic [CODE_W-1:0] sync_code,
    input  logic [NIRQ-1:0]   irq_lines,
    input  logic              rfe,
    input  logic              sw_we,
    input  logic [SEL_W-1:0]  sw_addr,
    input  logic [DW-1:0]     sw_wdata,
    output logic [DW-1:0]     sw_rdata,
    output logic              exc_taken,
    output logic [AW-1:0]     handler_pc,
    output logic              priv_mode,
    output logic              irq_en
);

    localparam int STK_W = LEVELS * LVL_W;

    logic [STK_W-1:0]  status_q;
    logic [AW-1:0]     epc_q;
    logic [DW-1:0]     cause_q;
    logic [CODE_W-1:0] entry_code;
    logic              st_we;
    logic              epc_we;
    logic              unused_wdata_hi;

    // Decode software writes to the writable registers.
    always_comb begin
        st_we  = sw_we && (reg_sel_e'(sw_addr) == SEL_STATUS);
        epc_we = sw_we && (reg_sel_e'(sw_addr) == SEL_EPC);
    end

    assign unused_wdata_hi = ^sw_wdata[DW-1:STK_W];

    exc_entry_sel #(
        .AW(AW), .NIRQ(NIRQ),
        .VEC_RESET(VEC_RESET), .VEC_XLAT(VEC_XLAT), .VEC_GENERAL(VEC_GENERAL)
    ) u_entry (
        .sync_req   (sync_req),
        .sync_class (sync_class),
        .sync_code  (sync_code),
        .irq_lines  (irq_lines),
        .ie_cur     (status_q[0]),
        .take       (exc_taken),
        .code       (entry_code),
        .vector     (handler_pc)
    );

    exc_mode_stack #(.LEVELS(LEVELS)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (exc_taken),
        .pop     (rfe && !exc_taken),
        .wr_en   (st_we),
        .wr_data (sw_wdata[STK_W-1:0]),
        .status  (status_q)
    );

    exc_capture_regs #(
        .AW(AW), .DW(DW), .NIRQ(NIRQ), .IRQ_LSB(IRQ_LSB)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (exc_taken),
        .pc_in     (pc_in),
        .code      (entry_code),
        .irq_lines (irq_lines),
        .epc_we    (epc_we),
        .epc_wdata (sw_wdata[AW-1:0]),
        .epc       (epc_q),
        .cause     (cause_q)
    );

    // Combinational software read mux.
    always_comb begin
        sw_rdata = '0;
        case (reg_sel_e'(sw_addr))
            SEL_STATUS: sw_rdata[STK_W-1:0] = status_q;
            SEL_CAUSE:  sw_rdata = cause_q;
            SEL_EPC:    sw_rdata[AW-1:0] = epc_q;
            default:    sw_rdata = '0;
        endcase
    end

    // Current mode outputs.
    always_comb begin
        priv_mode = status_q[1];
        irq_en    = status_q[0];
    end

endmodule

// File: rtl/exc_ctrl_unit_sva.sv
// Property checker for exc_ctrl_unit, bound to every instance.
module exc_ctrl_unit_sva #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int NIRQ = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sync_req,
    input logic [NIRQ-1:0] irq_lines,
    input logic            rfe,
    input logic [AW-1:0]   pc_in,
    input logic            exc_taken,
    input logic [AW-1:0]   handler_pc,
    input logic [5:0]      status,
    input logic [AW-1:0]   epc,
    input logic [DW-1:0]   cause
);

    assert_sync_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |-> exc_taken);

    assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_req && !status[0]) |-> !exc_taken);

    assert_idle_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken |-> (handler_pc == '0));

    assert_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (status[1:0] == 2'b10) && (status[3:2] == $past(status[1:0]))
                      && (status[5:4] == $past(status[3:2])));

    assert_epc_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (epc == $past(pc_in)));

    assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !exc_taken) |=> (status[1:0] == $past(status[3:2]))
                                && (status[3:2] == $past(status[5:4]))
                                && (status[5:4] == $past(status[5:4])));

    assert_cause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken |=> $stable(cause));

    assert_irq_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (cause[8 +: NIRQ] == $past(irq_lines)));

endmodule

bind exc_ctrl_unit exc_ctrl_unit_sva #(.AW(AW), .DW(DW), .NIRQ(NIRQ)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_req   (sync_req),
    .irq_lines  (irq_lines),
    .rfe        (rfe),
    .pc_in      (pc_in),
    .exc_taken  (exc_taken),
    .handler_pc (handler_pc),
    .status     (status_q),
    .epc        (epc_q),
    .cause      (cause_q)
);

// File: tb/exc_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module exc_ctrl_unit_tb_top;

    localparam logic [31:0] V_RST = 32'hBFC0_0000;
    localparam logic [31:0] V_XL  = 32'h8000_0000;
    localparam logic [31:0] V_GEN = 32'h8000_0080;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc_in;
    logic        sync_req;
    logic [1:0]  sync_class;
    logic [4:0]  sync_code;
    logic [5:0]  irq_lines;
    logic        rfe;
    logic        sw_we;
    logic [1:0]  sw_addr;
    logic [31:0] sw_wdata;
    logic [31:0] sw_rdata;
    logic        exc_taken;
    logic [31:0] handler_pc;
    logic        priv_mode;
    logic        irq_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    exc_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .sync_req(sync_req),
        .sync_class(sync_class), .sync_code(sync_code), .irq_lines(irq_lines),
        .rfe(rfe), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .exc_taken(exc_taken), .handler_pc(handler_pc),
        .priv_mode(priv_mode), .irq_en(irq_en)
    );

    typedef struct packed {
        logic        sreq;
        logic [1:0]  cls;
        logic [4:0]  code;
        logic [5:0]  irq;
        logic        ret;
        logic [31:0] pc;
        logic        e_take;
        logic [31:0] e_vec;
        logic [5:0]  e_stat;
        logic [31:0] e_cause;
        logic [31:0] e_epc;
    } vec_t;

    // Sequence starting from status 6'b000001.
    localparam vec_t TBL [9] = '{
        '{1'b0, 2'd0, 5'd0,  6'b000100, 1'b0, 32'h100, 1'b1, V_GEN, 6'b000110, 32'h0400, 32'h100},
        '{1'b0, 2'd0, 5'd0,  6'b000001, 1'b0, 32'h180, 1'b0, 32'h0, 6'b000110, 32'h0400, 32'h100},
        '{1'b1, 2'd0, 5'd8,  6'b000000, 1'b0, 32'h200, 1'b1, V_GEN, 6'b011010, 32'h0008, 32'h200},
        '{1'b0, 2'd0, 5'd0,  6'b000000, 1'b1, 32'h0,   1'b0, 32'h0, 6'b010110, 32'h0008, 32'h200},
        '{1'b0, 2'd0, 5'd0,  6'b000000, 1'b1, 32'h0,   1'b0, 32'h0, 6'b010101, 32'h0008, 32'h200},
        '{1'b1, 2'd1, 5'd2,  6'b100000, 1'b0, 32'h300, 1'b1, V_XL,  6'b010110, 32'h2002, 32'h300},
        '{1'b1, 2'd2, 5'd0,  6'b000000, 1'b1, 32'h400, 1'b1, V_RST, 6'b011010, 32'h0000, 32'h400},
        '{1'b0, 2'd0, 5'd0,  6'b000000, 1'b0, 32'h0,   1'b0, 32'h0, 6'b011010, 32'h0000, 32'h400},
        '{1'b1, 2'd3, 5'd31, 6'b000000, 1'b0, 32'h500, 1'b1, V_GEN, 6'b101010, 32'h001F, 32'h500}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        sw_addr = a;
        #1;
        d = sw_rdata;
    endtask

    task automatic idle_inputs();
        sync_req = 1'b0; sync_class = 2'd0; sync_code = 5'd0;
        irq_lines = '0; rfe = 1'b0; sw_we = 1'b0; pc_in = '0;
    endtask

    task automatic sw_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        idle_inputs();
        sw_addr = 2'd0; sw_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 mode outputs
        rd(2'd0, d); check("R1", "status after reset", d, 32'h2);
        rd(2'd1, d); check("R1", "cause after reset", d, 32'h0);
        rd(2'd2, d); check("R1", "epc after reset", d, 32'h0);
        check("R1", "exc_taken after reset", {31'b0, exc_taken}, 32'h0);
        check("R11", "priv_mode after reset", {31'b0, priv_mode}, 32'h1);
        check("R11", "irq_en after reset", {31'b0, irq_en}, 32'h0);

        // R9 status write, visible next cycle
        sw_write(2'd0, 32'h0000_0001);
        rd(2'd0, d); check("R9", "status written", d, 32'h1);
        check("R11", "priv_mode user", {31'b0, priv_mode}, 32'h0);
        check("R11", "irq_en set", {31'b0, irq_en}, 32'h1);

        // R2 boundary: enabled but no lines asserted
        @(negedge clk);
        #5 check("R2", "no take with quiet lines", {31'b0, exc_taken}, 32'h0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            sync_req = TBL[i].sreq; sync_class = TBL[i].cls; sync_code = TBL[i].code;
            irq_lines = TBL[i].irq; rfe = TBL[i].ret; pc_in = TBL[i].pc;
            #5;
            check("R2", $sformatf("take row %0d", i), {31'b0, exc_taken}, {31'b0, TBL[i].e_take});
            check("R3", $sformatf("vector row %0d", i), handler_pc, TBL[i].e_vec);
            @(negedge clk);
            idle_inputs();
            rd(2'd0, d); check("R4/R7", $sformatf("status row %0d", i), d, {26'b0, TBL[i].e_stat});
            rd(2'd1, d); check("R6", $sformatf("cause row %0d", i), d, TBL[i].e_cause);
            rd(2'd2, d); check("R5", $sformatf("epc row %0d", i), d, TBL[i].e_epc);
        end

        // R8 exception beats software status write
        @(negedge clk);
        sw_we = 1'b1; sw_addr = 2'd0; sw_wdata = 32'h1;
        sync_req = 1'b1; sync_code = 5'd3; pc_in = 32'h600;
        @(negedge clk);
        idle_inputs();
        rd(2'd0, d); check("R8", "exception over sw status write", d, 32'h2A);

        // R8 return beats software write; R7 old level kept
        sw_write(2'd0, 32'h31);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = 2'd0; sw_wdata = 32'h0; rfe = 1'b1;
        @(negedge clk);
        idle_inputs();
        rd(2'd0, d); check("R8", "rfe over sw status write", d, 32'h3C);

        // R8 exception beats software epc write
        @(negedge clk);
        sw_we = 1'b1; sw_addr = 2'd2; sw_wdata = 32'h1234;
        sync_req = 1'b1; pc_in = 32'h700;
        @(negedge clk);
        idle_inputs();
        rd(2'd2, d); check("R8", "exception over sw epc write", d, 32'h700);

        // R10 cause and unused address ignore writes
        rd(2'd1, d);
        sw_write(2'd1, 32'hFFFF_FFFF);
        begin
            logic [31:0] d2;
            rd(2'd1, d2); check("R10", "cause write ignored", d2, d);
        end
        rd(2'd0, d);
        sw_write(2'd3, 32'hFFFF_FFFF);
        begin
            logic [31:0] d3;
            rd(2'd3, d3); check("R10", "addr 3 reads zero", d3, 32'h0);
            rd(2'd0, d3); check("R10", "status unchanged by addr 3", d3, d);
        end

        // R9 epc write
        sw_write(2'd2, 32'hDEAD_BEE0);
        rd(2'd2, d); check("R9", "epc written", d, 32'hDEAD_BEE0);

        // R6 interrupt code is zero, lines recorded
        sw_write(2'd0, 32'h1);
        @(negedge clk);
        irq_lines = 6'b010010; pc_in = 32'h800;
        #5 check("R3", "interrupt uses general vector", handler_pc, V_GEN);
        @(negedge clk);
        idle_inputs();
        rd(2'd1, d); check("R6", "interrupt cause", d, 32'h1200);

        finish_run();
    end

endmodule